// File: doc/BRIEF.md
# Interrupt Stack Frame Push Sequencer

When an interrupt or exception is taken, this block writes the return frame onto the stack. A one-cycle start strobe delivers everything the frame needs: the current stack pointer and stack segment selector, the flags, the code segment selector, the return address, and an optional error code with its valid bit. On the same cycle, a mode select chooses between long mode and legacy mode. In legacy mode, a privilege-change flag and a gate width input also apply.

The block turns the frame into a series of memory write requests. Each request carries an address, data and a byte count, and moves over a valid/ready handshake. After the last write is accepted, a one-cycle done pulse presents the final stack pointer.

In long mode every item is 8 bytes wide, the pointer is first rounded down to a 16-byte boundary, and the old stack segment and pointer are always saved. In legacy mode there is no rounding, items are 2 or 4 bytes wide, and the old stack segment and pointer are saved only when the privilege level changes.

Top module: `stack_frame_pusher`

## Requirements
- R1: After reset, `wrValid` and `done` are low until a start strobe is accepted.
- R2: With `longMode`=1, every write has `wrSize`=8, and the old selector and pointer are written whatever `privChange` is.
- R3: With `longMode`=1, the working pointer is `spIn` with its low four bits cleared, so the first write lands at that value minus 8.
- R4: With `longMode`=0 and `privChange`=0, only flags, code selector, return address (and the error code if valid) are written. The first write is at `spIn` minus the item width, with no alignment.
- R5: With `longMode`=0, the item width is 4 bytes when `gateWide`=1 and 2 bytes when `gateWide`=0. With `privChange`=1, the old selector and pointer are written first.
- R6: The saved stack pointer item holds the original `spIn` (before alignment), cut to the item width.
- R7: Items are written in this order: old stack selector, old pointer, flags, code selector, return address, error code. Each address equals the previous working pointer minus the item width.
- R8: `wrData` holds the item value, zero-extended from its low `wrSize` bytes; the 16-bit selectors are zero-extended.
- R9: The error code is written as the last item exactly when `errValid` was 1 at start.
- R10: A start strobe that arrives while a frame is in progress is ignored and does not change the frame being written.
- R11: While `wrValid`=1 and `wrReady`=0, `wrValid`, `wrAddr`, `wrData` and `wrSize` hold their values.
- R12: `done` is high for exactly one cycle, the cycle after the last write is accepted. At that time `spOut` equals the address of the last write, and `wrValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a frame (accepted only when idle) |
| longMode | input | 1 | 1 = long mode, 0 = legacy mode |
| privChange | input | 1 | Legacy mode: privilege level changes |
| gateWide | input | 1 | Legacy mode: 1 = 4-byte items, 0 = 2-byte items |
| spIn | input | 64 | Current stack pointer |
| ssIn | input | 16 | Current stack segment selector |
| flagsIn | input | 64 | Flags value to save |
| csIn | input | 16 | Code segment selector to save |
| retAddr | input | 64 | Return address to save |
| errCode | input | 64 | Error code value |
| errValid | input | 1 | Error code is present |
| wrValid | output | 1 | Write request valid |
| wrReady | input | 1 | Memory accepts the write |
| wrAddr | output | 64 | Write byte address |
| wrData | output | 64 | Write data, zero-extended |
| wrSize | output | 4 | Write size in bytes (2, 4 or 8) |
| done | output | 1 | Frame complete pulse |
| spOut | output | 64 | Final stack pointer, valid with `done` |

## Verification
The assertions assume three things. First, `wrReady` is a free input that may stall for any number of cycles. Second, a frame's item width never changes once it starts. Third, in long mode the pointer actually reaches memory through the aligned path, so the first 8-byte write sits 8 below a 16-byte boundary. The stimulus keeps inputs stable around the start cycle and draws stack pointers, widths, modes and error presence from a seeded random source, with `wrReady` randomly stalled. Directed frames cover an already aligned pointer, an odd legacy pointer, and a stray start strobe in the middle of a frame.

// File: rtl/frame_push_pkg.sv
package frame_push_pkg;

  // Frame items in push order; control steps through these in sequence.
  typedef enum logic [2:0] {
    IT_SS    = 3'd0,
    IT_SP    = 3'd1,
    IT_FLAGS = 3'd2,
    IT_CS    = 3'd3,
    IT_RET   = 3'd4,
    IT_ERR   = 3'd5
  } itemT;

  typedef struct packed {
    logic load;  // capture the frame inputs and the starting pointer
    logic step;  // a write was accepted: move the pointer down
    itemT item;  // item currently presented
  } ctrlT;

  localparam logic [3:0] SIZE_NARROW = 4'd2;
  localparam logic [3:0] SIZE_WIDE   = 4'd4;
  localparam logic [3:0] SIZE_LONG   = 4'd8;
  localparam int         ALIGN_BITS  = 4;

endpackage

// File: rtl/frame_push_ctl.sv
module frame_push_ctl
  import frame_push_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic longMode,
  input  logic privChange,
  input  logic errValid,
  input  logic wrReady,
  output logic wrValid,
  output logic done,
  output ctrlT ctrl
);

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_DONE} stateT;

  stateT stateQ;
  itemT  itemQ;
  logic  errKeepQ;
  logic  lastItem;

  assign lastItem = (itemQ == IT_ERR) || (itemQ == IT_RET && !errKeepQ);

  always_comb begin
    ctrl.load = (stateQ == S_IDLE) && startReq;
    ctrl.step = (stateQ == S_PUSH) && wrReady;
    ctrl.item = itemQ;
  end

  assign wrValid = (stateQ == S_PUSH);
  assign done    = (stateQ == S_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      itemQ    <= IT_SS;
      errKeepQ <= 1'b0;
    end else begin
      case (stateQ)
        S_IDLE: if (startReq) begin
          stateQ   <= S_PUSH;
          errKeepQ <= errValid;
          itemQ    <= (longMode || privChange) ? IT_SS : IT_FLAGS;
        end
        S_PUSH: if (wrReady) begin
          if (lastItem) stateQ <= S_DONE;
          else          itemQ  <= itemT'(3'(itemQ + 3'd1));
        end
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  // R12: the completion pulse lasts one cycle and no write follows it at once
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !wrValid);

  // R10: a stalled write keeps the sequence busy whatever startReq does
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> wrValid && $stable(itemQ));

endmodule

// File: rtl/frame_push_dp.sv
module frame_push_dp
  import frame_push_pkg::*;
#(
  parameter int AW   = 64,
  parameter int DW   = 64,
  parameter int SELW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlT            ctrl,
  input  logic            longMode,
  input  logic            gateWide,
  input  logic [AW-1:0]   spIn,
  input  logic [SELW-1:0] ssIn,
  input  logic [DW-1:0]   flagsIn,
  input  logic [SELW-1:0] csIn,
  input  logic [DW-1:0]   retAddr,
  input  logic [DW-1:0]   errCode,
  output logic [AW-1:0]   wrAddr,
  output logic [DW-1:0]   wrData,
  output logic [3:0]      wrSize,
  output logic [AW-1:0]   spOut
);

  localparam logic [AW-1:0] ALIGN_MASK = ~AW'((1 << ALIGN_BITS) - 1);

  logic [AW-1:0]   ptrQ;
  logic [3:0]      widthQ;
  logic [AW-1:0]   spSaveQ;
  logic [SELW-1:0] ssQ, csQ;
  logic [DW-1:0]   flagsQ, retQ, errQ;
  logic [DW-1:0]   rawData;
  logic [DW-1:0]   keepMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ    <= '0;
      widthQ  <= SIZE_LONG;
      spSaveQ <= '0;
      ssQ     <= '0;
      csQ     <= '0;
      flagsQ  <= '0;
      retQ    <= '0;
      errQ    <= '0;
    end else if (ctrl.load) begin
      ptrQ    <= longMode ? (spIn & ALIGN_MASK) : spIn;
      widthQ  <= longMode ? SIZE_LONG : (gateWide ? SIZE_WIDE : SIZE_NARROW);
      spSaveQ <= spIn;
      ssQ     <= ssIn;
      csQ     <= csIn;
      flagsQ  <= flagsIn;
      retQ    <= retAddr;
      errQ    <= errCode;
    end else if (ctrl.step) begin
      ptrQ <= wrAddr;
    end
  end

  always_comb begin
    case (ctrl.item)
      IT_SS:    rawData = DW'(ssQ);
      IT_SP:    rawData = DW'(spSaveQ);
      IT_FLAGS: rawData = flagsQ;
      IT_CS:    rawData = DW'(csQ);
      IT_RET:   rawData = retQ;
      default:  rawData = errQ;
    endcase
    case (widthQ)
      SIZE_NARROW: keepMask = DW'(16'hFFFF);
      SIZE_WIDE:   keepMask = DW'(32'hFFFF_FFFF);
      default:     keepMask = '1;
    endcase
  end

  assign wrAddr = ptrQ - AW'(widthQ);
  assign wrData = rawData & keepMask;
  assign wrSize = widthQ;
  assign spOut  = ptrQ;

endmodule

// File: rtl/stack_frame_pusher.sv
module stack_frame_pusher
  import frame_push_pkg::*;
#(
  parameter int AW   = 64,
  parameter int DW   = 64,
  parameter int SELW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic            longMode,
  input  logic            privChange,
  input  logic            gateWide,
  input  logic [AW-1:0]   spIn,
  input  logic [SELW-1:0] ssIn,
  input  logic [DW-1:0]   flagsIn,
  input  logic [SELW-1:0] csIn,
  input  logic [DW-1:0]   retAddr,
  input  logic [DW-1:0]   errCode,
  input  logic            errValid,
  output logic            wrValid,
  input  logic            wrReady,
  output logic [AW-1:0]   wrAddr,
  output logic [DW-1:0]   wrData,
  output logic [3:0]      wrSize,
  output logic            done,
  output logic [AW-1:0]   spOut
);

  ctrlT ctrl;

  frame_push_ctl u_ctl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .longMode(longMode),
    .privChange(privChange), .errValid(errValid), .wrReady(wrReady),
    .wrValid(wrValid), .done(done), .ctrl(ctrl)
  );

  frame_push_dp #(.AW(AW), .DW(DW), .SELW(SELW)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .longMode(longMode),
    .gateWide(gateWide), .spIn(spIn), .ssIn(ssIn), .flagsIn(flagsIn),
    .csIn(csIn), .retAddr(retAddr), .errCode(errCode),
    .wrAddr(wrAddr), .wrData(wrData), .wrSize(wrSize), .spOut(spOut)
  );

  // R11: a stalled request is held unchanged
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> wrValid && $stable(wrAddr) && $stable(wrData) && $stable(wrSize));

  // R7: the next write of the same frame sits one item width lower
  a_r7_descend: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady) |=> !wrValid || (wrAddr == $past(wrAddr) - AW'($past(wrSize))));

  // R3: the first 8-byte write of a frame lies 8 below a 16-byte boundary
  a_r3_first_aligned: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(wrValid) && wrSize == SIZE_LONG) |-> wrAddr[3:0] == 4'h8);

  // R2 / R5: only the legal item widths appear
  a_r5_size_legal: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrSize == SIZE_NARROW || wrSize == SIZE_WIDE || wrSize == SIZE_LONG));

endmodule

// File: tb/stack_frame_pusher_tb.sv
module stack_frame_pusher_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        startReq, longMode, privChange, gateWide, errValid, wrReady;
  logic [63:0] spIn, flagsIn, retAddr, errCode;
  logic [15:0] ssIn, csIn;
  logic        wrValid, done;
  logic [63:0] wrAddr, wrData, spOut;
  logic [3:0]  wrSize;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  logic [63:0] expAddr [6];
  logic [63:0] expData [6];
  int          expN;
  logic [3:0]  expW;
  logic [63:0] expFinal;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_frame_pusher u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .longMode(longMode),
    .privChange(privChange), .gateWide(gateWide), .spIn(spIn), .ssIn(ssIn),
    .flagsIn(flagsIn), .csIn(csIn), .retAddr(retAddr), .errCode(errCode),
    .errValid(errValid), .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr),
    .wrData(wrData), .wrSize(wrSize), .done(done), .spOut(spOut)
  );

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles >= WATCHDOG);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] fit(input logic [63:0] v, input logic [3:0] w);
    if (w == 4'd2) return {48'b0, v[15:0]};
    if (w == 4'd4) return {32'b0, v[31:0]};
    return v;
  endfunction

  // Expected frame from the requirements (R2..R9)
  task automatic buildExp();
    logic [63:0] p;
    logic [63:0] vals [6];
    bit          use6 [6];
    expW = longMode ? 4'd8 : (gateWide ? 4'd4 : 4'd2);
    p = longMode ? (spIn & ~64'hF) : spIn;
    vals[0] = {48'b0, ssIn}; vals[1] = spIn; vals[2] = flagsIn;
    vals[3] = {48'b0, csIn}; vals[4] = retAddr; vals[5] = errCode;
    use6[0] = longMode || privChange; use6[1] = use6[0];
    use6[2] = 1; use6[3] = 1; use6[4] = 1; use6[5] = errValid;
    expN = 0;
    for (int i = 0; i < 6; i++) begin
      if (use6[i]) begin
        p = p - {60'b0, expW};
        expAddr[expN] = p;
        expData[expN] = fit(vals[i], expW);
        expN++;
      end
    end
    expFinal = p;
  endtask

  task automatic runFrame(input bit lm, input bit pc, input bit gw, input bit ev,
                          input logic [63:0] sp, input bit alwaysReady, input bit stray);
    int idx = 0;
    int guard = 0;
    bit stallPrev = 0;
    logic [63:0] hA, hD;
    logic [3:0]  hS;
    @(negedge clk);
    longMode = lm; privChange = pc; gateWide = gw; errValid = ev; spIn = sp;
    ssIn = 16'($urandom); csIn = 16'($urandom);
    flagsIn = {$urandom, $urandom}; retAddr = {$urandom, $urandom};
    errCode = {$urandom, $urandom};
    buildExp();
    startReq = 1; wrReady = 0;
    @(negedge clk);
    startReq = 0;
    while (!done && guard < 200) begin
      startReq = 0;
      if (wrValid) begin
        if (stallPrev)
          check(wrAddr == hA && wrData == hD && wrSize == hS, "R11 held request", wrAddr, hA);
        wrReady = alwaysReady ? 1'b1 : ($urandom % 3 != 0);
        if (stray && idx == 1) begin
          startReq = 1; spIn = 64'h1234_5678_9ABC_DEF1; longMode = ~lm; privChange = 1;
        end
        if (wrReady) begin
          if (idx < expN) begin
            check(wrAddr == expAddr[idx], "R3/R4/R7 write address", wrAddr, expAddr[idx]);
            check(wrData == expData[idx], "R2/R6/R8/R9 write data", wrData, expData[idx]);
            check(wrSize == expW, "R2/R5 write size", {60'b0, wrSize}, {60'b0, expW});
          end else begin
            check(0, "R9/R10 extra write", 64'(idx), 64'(expN));
          end
          idx++;
        end
        stallPrev = !wrReady; hA = wrAddr; hD = wrData; hS = wrSize;
      end else begin
        wrReady = 0;
        stallPrev = 0;
      end
      @(negedge clk);
      guard++;
    end
    startReq = 0; wrReady = 0;
    check(done == 1'b1, "R12 done seen", 64'(done), 64'd1);
    check(idx == expN, "R7/R9 write count", 64'(idx), 64'(expN));
    check(spOut == expFinal, "R12 final pointer", spOut, expFinal);
    check(wrValid == 1'b0, "R12 no write with done", 64'(wrValid), 64'd0);
    @(negedge clk);
    check(done == 1'b0 && wrValid == 1'b0, "R12/R10 one-cycle done, stray start ignored",
          {62'b0, done, wrValid}, 64'd0);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd4242);
    rstN = 0; startReq = 0; longMode = 0; privChange = 0; gateWide = 0;
    errValid = 0; wrReady = 0; spIn = '0; ssIn = '0; csIn = '0;
    flagsIn = '0; retAddr = '0; errCode = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(wrValid == 1'b0 && done == 1'b0, "R1 reset state", {62'b0, wrValid, done}, 64'd0);
    wrReady = 1;
    @(negedge clk);
    check(wrValid == 1'b0, "R1 idle ignores ready", 64'(wrValid), 64'd0);

    // Directed corner cases
    runFrame(1, 0, 0, 0, 64'h0000_0000_0000_1000, 1, 0); // R3 already aligned, R2 no priv change
    runFrame(1, 1, 1, 1, 64'h0000_7FFF_0000_100F, 0, 0); // R3 misaligned, R6 original pointer
    runFrame(0, 0, 1, 0, 64'h0000_0000_0000_2003, 1, 0); // R4 no alignment, no SS/SP
    runFrame(0, 1, 0, 1, 64'h0000_0000_0000_0FFF, 0, 0); // R5 2-byte items, R8 truncation
    runFrame(0, 1, 1, 1, 64'h0000_0000_8000_0002, 0, 0); // R5 4-byte items, R9 error code
    runFrame(0, 0, 0, 0, 64'h0000_0000_0000_0101, 0, 1); // R10 stray start mid-frame
    runFrame(1, 0, 0, 1, 64'hFFFF_8000_0000_0007, 0, 1); // R10 stray start in long mode

    // Constrained random frames
    for (int n = 0; n < 60; n++) begin
      runFrame(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               {$urandom, $urandom}, 1'($urandom % 4 == 0), 1'($urandom % 8 == 0));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule